// File: doc/BRIEF.md
# Parallel Port Peripheral Handshake Controller

This block is the printer-side end of a bidirectional parallel port. It receives forward bytes from the host using the plain strobe/acknowledge handshake. It recognises a host's request to switch into a bidirectional mode. Once that request is granted, it hands bytes back to the host a whole byte at a time. All host control lines are brought into the local clock domain through two-flop synchronizers, and the block acts only on edges of the synchronized copies.

On the internal side, a consumer takes received bytes through a valid/take pair, and a producer offers reverse bytes through a load/ready pair. The paper-empty, busy and fault indications come from software-controlled inputs; only the handshake adds to busy. The data bus output enable is raised only while a reverse byte is being presented. Outside that window the host owns the wires.

Top module: `par_periph_ctrl`

## Requirements
- R1: After reset, ack_n=1, busy=sw_busy, sel=1, bus_oe=0, rx_valid=0, tx_ready=1 and byte_mode=0.
- R2: In forward mode, a falling edge of host_strobe_n latches bus_in into rx_data while busy is low, and raises rx_valid. The latch happens on the third rising clock edge after the input change (two synchronizer flops plus the edge detect). bus_in[0] is data line 1 and bus_in[7] is data line 8.
- R3: busy is high from the latch until the byte is taken with rx_take, through the acknowledge pulse, and whenever sw_busy is high. A strobe edge seen while busy is high does not change rx_data or rx_valid.
- R4: The clock edge that sees rx_take with rx_valid high clears rx_valid and drives ack_n low for exactly ACK_CYCLES cycles.
- R5: In forward mode with nothing pending, host_selin high together with host_autofd_n low starts negotiation. ack_n goes low and sel is forced to 1.
- R6: During negotiation the value on bus_in at the strobe's falling edge is captured as the request. When strobe and autofd are both high again, ack_n returns high. A request equal to BYTE_REQ (default 8'h01) sets sel=1 and byte_mode=1.
- R7: Any other request value returns the block to forward mode with sel=0. sel stays 0 until the next negotiation starts.
- R8: In byte mode, with a byte loaded through tx_load and host_autofd_n low, the block drives bus_out with the byte for one cycle and then pulls ack_n low. When autofd goes high, ack_n rises. The host's next strobe falling edge releases the bus, frees the transmit holding register (tx_ready=1) and latches nothing into rx_data.
- R9: bus_oe is high only during byte-mode presentation of a loaded byte. It is never high in forward mode or during negotiation.
- R10: host_selin going low while in byte mode returns the block to forward mode (byte_mode=0, bus_oe=0).
- R11: perr follows sw_perr, fault_n is the inverse of sw_fault, and sw_busy is ORed into busy in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_strobe_n | input | 1 | Host strobe / host clock, active low |
| host_selin | input | 1 | Host select-in; high requests the extended protocol |
| host_autofd_n | input | 1 | Host auto-feed / host busy line |
| bus_in | input | 8 | Data bus as seen at the pins |
| bus_out | output | 8 | Reverse byte driven onto the bus |
| bus_oe | output | 1 | Output enable for bus_out |
| ack_n | output | 1 | Acknowledge / peripheral clock, active low |
| busy | output | 1 | Busy line |
| sel | output | 1 | Select line carrying the extensibility flag |
| perr | output | 1 | Paper-empty line |
| fault_n | output | 1 | Fault line, active low |
| sw_busy | input | 1 | Software busy request |
| sw_perr | input | 1 | Software paper-empty flag |
| sw_fault | input | 1 | Software fault flag |
| rx_data | output | 8 | Last received forward byte |
| rx_valid | output | 1 | rx_data holds an untaken byte |
| rx_take | input | 1 | Consumer takes rx_data |
| tx_data | input | 8 | Reverse byte to send |
| tx_load | input | 1 | Load tx_data when tx_ready is high |
| tx_ready | output | 1 | Transmit holding register is empty |
| byte_mode | output | 1 | Block is in the byte-wide reverse phase |

## Verification
The bench builds the block with ACK_CYCLES=3 and the default BYTE_REQ of 8'h01. The short pulse lets many forward transfers, a rejected negotiation, an accepted negotiation, two reverse bytes and a termination fit into a short run. A behavioural model follows the synchronizer latency and compares every output on every cycle. That comparison exposes off-by-one errors in the acknowledge width and in edge timing. Directed checks also cover strobes arriving while the block is busy and the single request value that is accepted.

// File: rtl/par_periph_ctrl.sv
module par_periph_ctrl #(
  parameter int ACK_CYCLES = 4,
  parameter logic [7:0] BYTE_REQ = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_strobe_n,
  input  logic       host_selin,
  input  logic       host_autofd_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic       ack_n,
  output logic       busy,
  output logic       sel,
  output logic       perr,
  output logic       fault_n,
  input  logic       sw_busy,
  input  logic       sw_perr,
  input  logic       sw_fault,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_take,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_ready,
  output logic       byte_mode
);
  localparam int CW = $clog2(ACK_CYCLES + 1);
  localparam logic [CW-1:0] ACK_LOAD = CW'(ACK_CYCLES);

  typedef enum logic [2:0] {
    ST_FWD, ST_NEG_CLK, ST_NEG_REL, ST_REV_IDLE, ST_REV_SETUP, ST_REV_CLK, ST_REV_HOLD
  } state_t;

  state_t state;
  logic [2:0] stb_q;
  logic [1:0] sel_q, afd_q;
  logic [CW-1:0] ack_cnt;
  logic rx_full, tx_full, xflag;
  logic [7:0] rx_byte, tx_byte, req;

  wire stb_s    = stb_q[1];
  wire stb_fall = stb_q[2] & ~stb_q[1];
  wire sel_s    = sel_q[1];
  wire afd_s    = afd_q[1];
  wire ack_busy = (ack_cnt != '0);

  assign busy      = sw_busy | rx_full | ack_busy;
  assign rx_data   = rx_byte;
  assign rx_valid  = rx_full;
  assign tx_ready  = ~tx_full;
  assign bus_out   = tx_byte;
  assign bus_oe    = (state == ST_REV_SETUP) || (state == ST_REV_CLK) || (state == ST_REV_HOLD);
  assign byte_mode = (state == ST_REV_IDLE) || bus_oe;
  assign sel       = xflag;
  assign perr      = sw_perr;
  assign fault_n   = ~sw_fault;

  always_comb begin
    case (state)
      ST_FWD:                          ack_n = ~ack_busy;
      ST_NEG_CLK, ST_NEG_REL, ST_REV_CLK: ack_n = 1'b0;
      default:                         ack_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 3'b111;
      sel_q   <= 2'b00;
      afd_q   <= 2'b11;
      state   <= ST_FWD;
      ack_cnt <= '0;
      rx_full <= 1'b0;
      rx_byte <= '0;
      tx_full <= 1'b0;
      tx_byte <= '0;
      req     <= '0;
      xflag   <= 1'b1;
    end else begin
      stb_q <= {stb_q[1:0], host_strobe_n};
      sel_q <= {sel_q[0], host_selin};
      afd_q <= {afd_q[0], host_autofd_n};
      if (ack_busy) ack_cnt <= ack_cnt - 1'b1;
      if (rx_take && rx_full) begin
        rx_full <= 1'b0;
        ack_cnt <= ACK_LOAD;
      end
      if (tx_load && !tx_full) begin
        tx_full <= 1'b1;
        tx_byte <= tx_data;
      end
      case (state)
        ST_FWD:
          if (sel_s && !afd_s && !rx_full && !ack_busy) begin
            state <= ST_NEG_CLK;
            xflag <= 1'b1;
          end else if (stb_fall && !busy) begin
            rx_byte <= bus_in;
            rx_full <= 1'b1;
          end
        ST_NEG_CLK:
          if (!sel_s) state <= ST_FWD;
          else if (stb_fall) begin
            req   <= bus_in;
            state <= ST_NEG_REL;
          end
        ST_NEG_REL:
          if (!sel_s) state <= ST_FWD;
          else if (stb_s && afd_s) begin
            xflag <= (req == BYTE_REQ);
            state <= (req == BYTE_REQ) ? ST_REV_IDLE : ST_FWD;
          end
        ST_REV_IDLE:
          if (!sel_s) state <= ST_FWD;
          else if (tx_full && !afd_s) state <= ST_REV_SETUP;
        ST_REV_SETUP:
          state <= sel_s ? ST_REV_CLK : ST_FWD;
        ST_REV_CLK:
          if (!sel_s) state <= ST_FWD;
          else if (afd_s) state <= ST_REV_HOLD;
        ST_REV_HOLD:
          if (!sel_s) state <= ST_FWD;
          else if (stb_fall) begin
            tx_full <= 1'b0;
            state   <= ST_REV_IDLE;
          end
        default: state <= ST_FWD;
      endcase
    end
  end

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_take) |=> (rx_full && $stable(rx_byte)));

  assert_ack_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_take) |=> (!ack_n && !rx_full));

  assert_latch_only_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> ($past(state) == ST_FWD));

  assert_oe_has_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> tx_full);

  assert_req_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEG_CLK && sel_s && stb_fall) |=> (req == $past(bus_in)));

  assert_grant_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_mode) |-> (sel && ack_n));

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEG_REL && sel_s && stb_s && afd_s && req != BYTE_REQ) |=> (!sel && !byte_mode));
endmodule

// File: tb/par_periph_ctrl_tb.sv
module par_periph_ctrl_tb_top;
  localparam int ACK = 3;
  localparam logic [7:0] REQ_OK = 8'h01;

  logic clk = 0, rst_n = 0;
  logic host_strobe_n = 1, host_selin = 0, host_autofd_n = 1;
  logic [7:0] bus_in = 0, tx_data = 0;
  logic sw_busy = 0, sw_perr = 0, sw_fault = 0, rx_take = 0, tx_load = 0;
  logic [7:0] bus_out, rx_data;
  logic bus_oe, ack_n, busy, sel, perr, fault_n, rx_valid, tx_ready, byte_mode;

  always #10 clk = ~clk;

  par_periph_ctrl #(.ACK_CYCLES(ACK), .BYTE_REQ(REQ_OK)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_strobe_n(host_strobe_n), .host_selin(host_selin),
    .host_autofd_n(host_autofd_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ack_n(ack_n), .busy(busy), .sel(sel), .perr(perr), .fault_n(fault_n),
    .sw_busy(sw_busy), .sw_perr(sw_perr), .sw_fault(sw_fault), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_take(rx_take), .tx_data(tx_data), .tx_load(tx_load),
    .tx_ready(tx_ready), .byte_mode(byte_mode));

  int vectors = 0, miscompares = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 fwd, 1 wait request strobe, 2 wait release,
  // 3 reverse idle, 4 present, 5 clock low, 6 wait host confirm
  int ph = 0, ackleft = 0;
  bit q_st[3], q_sl[2], q_af[2];
  bit m_rxf = 0, m_txf = 0, m_flag = 1;
  logic [7:0] m_rx = 0, m_tx = 0, m_req = 0;
  bit fall, old_rxf, old_txf, m_busy;
  int old_ack;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; ackleft = 0; m_rxf = 0; m_txf = 0; m_flag = 1; m_rx = 0; m_tx = 0; m_req = 0;
      q_st = '{1, 1, 1}; q_sl = '{0, 0}; q_af = '{1, 1};
    end else begin
      fall = q_st[2] && !q_st[1];
      old_rxf = m_rxf; old_txf = m_txf; old_ack = ackleft;
      m_busy = sw_busy || old_rxf || (old_ack > 0);
      if (ackleft > 0) ackleft--;
      if (rx_take && old_rxf) begin m_rxf = 0; ackleft = ACK; end
      if (tx_load && !old_txf) begin m_txf = 1; m_tx = tx_data; end
      if (ph != 0 && !q_sl[1] && ph != 4) ph = 0;
      else case (ph)
        0: if (q_sl[1] && !q_af[1] && !old_rxf && old_ack == 0) begin ph = 1; m_flag = 1; end
           else if (fall && !m_busy) begin m_rx = bus_in; m_rxf = 1; end
        1: if (fall) begin m_req = bus_in; ph = 2; end
        2: if (q_st[1] && q_af[1]) begin m_flag = (m_req == REQ_OK); ph = m_flag ? 3 : 0; end
        3: if (old_txf && !q_af[1]) ph = 4;
        4: ph = q_sl[1] ? 5 : 0;
        5: if (q_af[1]) ph = 6;
        6: if (fall) begin m_txf = 0; ph = 3; end
        default: ph = 0;
      endcase
      q_st[2] = q_st[1]; q_st[1] = q_st[0]; q_st[0] = host_strobe_n;
      q_sl[1] = q_sl[0]; q_sl[0] = host_selin;
      q_af[1] = q_af[0]; q_af[0] = host_autofd_n;
    end
  end

  bit e_ack, e_oe, e_bm;
  always @(negedge clk) begin
    if (rst_n) begin
      e_oe = (ph >= 4);
      e_bm = (ph >= 3);
      e_ack = (ph == 0) ? (ackleft == 0) : !(ph == 1 || ph == 2 || ph == 5);
      chk(ack_n == e_ack, "R4 ack_n", ack_n, e_ack);
      chk(busy == (sw_busy || m_rxf || ackleft > 0), "R3 busy", busy, (sw_busy || m_rxf || ackleft > 0));
      chk(sel == m_flag, "R6 sel", sel, m_flag);
      chk(bus_oe == e_oe, "R9 bus_oe", bus_oe, e_oe);
      if (e_oe) chk(bus_out == m_tx, "R8 bus_out", bus_out, m_tx);
      chk(rx_valid == m_rxf, "R2 rx_valid", rx_valid, m_rxf);
      if (m_rxf) chk(rx_data == m_rx, "R2 rx_data", rx_data, m_rx);
      chk(tx_ready == !m_txf, "R8 tx_ready", tx_ready, !m_txf);
      chk(byte_mode == e_bm, "R10 byte_mode", byte_mode, e_bm);
      chk(perr == sw_perr && fault_n == !sw_fault, "R11 status", {perr, fault_n}, {sw_perr, !sw_fault});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] d);
    bus_in = d; cyc(1);
    host_strobe_n = 0; cyc(3);
    host_strobe_n = 1; cyc(2);
  endtask

  task automatic take();
    rx_take = 1; cyc(1); rx_take = 0; cyc(ACK + 2);
  endtask

  task automatic wait_ack(input bit lvl);
    for (int i = 0; i < 20 && ack_n != lvl; i++) cyc(1);
  endtask

  task automatic negotiate(input logic [7:0] r);
    bus_in = r; host_selin = 1; host_autofd_n = 0; cyc(5);
    chk(ack_n == 0 && sel == 1, "R5 negotiation entry", {ack_n, sel}, 2'b01);
    strobe(r);
    host_autofd_n = 1; cyc(5);
  endtask

  task automatic send_rev(input logic [7:0] d);
    tx_data = d; tx_load = 1; cyc(1); tx_load = 0;
    host_autofd_n = 0; wait_ack(0);
    chk(bus_oe && bus_out == d, "R8 byte presented", bus_out, d);
    host_autofd_n = 1; wait_ack(1);
    strobe(8'hEE); cyc(2);
    chk(!bus_oe && tx_ready && !rx_valid, "R8 released after confirm", {bus_oe, tx_ready, rx_valid}, 3'b010);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk(ack_n && !busy && sel && !bus_oe && !rx_valid && tx_ready && !byte_mode,
        "R1 reset state", {ack_n, busy, sel, bus_oe, rx_valid, tx_ready, byte_mode}, 7'b1010010);
    sw_perr = 1; sw_fault = 1; cyc(2); sw_perr = 0; cyc(1); sw_fault = 0; cyc(1);
    strobe(8'hA5);
    chk(rx_valid && rx_data == 8'hA5, "R2 forward byte", rx_data, 8'hA5);
    strobe(8'h3C);
    chk(rx_data == 8'hA5, "R3 strobe ignored while busy", rx_data, 8'hA5);
    take();
    strobe(8'h01);
    chk(rx_data[0] == 1'b1 && rx_data[7:1] == 0, "R2 line 1 is bit 0", rx_data, 8'h01);
    take();
    strobe(8'h80);
    chk(rx_data == 8'h80, "R2 line 8 is bit 7", rx_data, 8'h80);
    take();
    sw_busy = 1; cyc(1); strobe(8'h77);
    chk(!rx_valid && busy, "R11 sw_busy blocks latch", {rx_valid, busy}, 2'b01);
    sw_busy = 0; cyc(2);
    negotiate(8'h55);
    chk(!sel && !byte_mode && ack_n, "R7 request rejected", {sel, byte_mode, ack_n}, 3'b001);
    host_selin = 0; cyc(3);
    strobe(8'h42);
    chk(rx_valid && rx_data == 8'h42, "R7 forward after reject", rx_data, 8'h42);
    take();
    negotiate(REQ_OK);
    chk(sel && byte_mode && ack_n, "R6 request granted", {sel, byte_mode, ack_n}, 3'b111);
    send_rev(8'hC3);
    send_rev(8'h5A);
    host_selin = 0; cyc(4);
    chk(!byte_mode && !bus_oe, "R10 termination", {byte_mode, bus_oe}, 2'b00);
    strobe(8'h99);
    chk(rx_data == 8'h99, "R2 forward after termination", rx_data, 8'h99);
    take();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R1..run actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule